// File: doc/BRIEF.md
# Up/Down and Center-Aligned Timer Counter

The block is a 16-bit timer counter driven by a small register port. Software picks one of four alignment modes. Edge-aligned mode counts in one direction, set by a direction bit. The three center-aligned modes count up to the reload limit and back down to zero, over and over. A compare register is matched against the count. The resulting sticky flag can be gated by the count direction, so a center-aligned waveform can flag the rising slope, the falling slope or both.

The reload limit can be written straight into the active register. It can also be staged in a shadow copy that takes over only at the next update event. A one-pulse option turns the counter off at its first update event. A free-running divider gives a one-cycle sampling strobe every 1, 2 or 4 clocks for input filters elsewhere in the chip. The strobe keeps running whether the counter is enabled or not.

The register map has four word addresses: 0 is control, 1 is reload, 2 is compare and 3 is status. Control fields are: bit 0 run enable, bit 1 one-pulse, bit 2 direction (1 = down), bits 4:3 alignment mode, bit 5 reload buffering, and bits 9:8 strobe division. Status bit 0 is the update flag and bit 1 is the compare flag.

Top module: `updown_timer`

## Requirements
- R1: After reset every register and the count read 0, updPulse and cmpFlag are low, and control bits 15:10 and 7:6 always read 0 whatever is written.
- R2: In mode 00 with run set, the count steps once per clock. Counting up, it goes from the reload value (or anything above it) to 0. Counting down, it goes from 0 to the reload value. updPulse is high during the clock in which the wrap occurs.
- R3: In modes 01, 10 and 11 the count rises to the reload value, then falls to 0, then rises again. updPulse is high during the clock at each turning point. With run clear the count holds.
- R4: A compare match is count equal to the compare register while run is set. It sets the compare flag in mode 00 and mode 11, only while counting down in mode 01, and only while counting up in mode 10.
- R5: In a center-aligned mode, control bit 2 reads the current hardware count direction (1 = down), and writes to it are ignored. When the mode field changes value, the hardware direction restarts as up.
- R6: A control write that would change the mode from 00 to a nonzero value while run is 1 leaves the mode at 00. The other fields of that write still take effect.
- R7: With bit 5 clear, a reload write takes effect at once. With bit 5 set, the written value is staged and becomes active at the next update event. Address 1 reads back the last written value.
- R8: With one-pulse set, hardware clears run at the first update event. The count stops on the wrapped value and stays there.
- R9: The update and compare flags are sticky. Writing address 3 with a flag's bit at 0 clears that flag, and writing 1 leaves it unchanged.
- R10: sampleStb pulses once every 1, 2 or 4 clocks for division codes 00, 01 and 10. Code 11 behaves as 00. The strobe runs while the counter is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register word address for reads and writes |
| regWr | input | 1 | Write strobe, one register per clock |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr (combinational) |
| cntVal | output | 16 | Current counter value |
| updPulse | output | 1 | Update event, high for the wrapping/turning clock |
| cmpFlag | output | 1 | Sticky compare flag (mirrors status bit 1) |
| sampleStb | output | 1 | Divided sampling-clock enable strobe |

## Verification
A wrong count or direction register shows at cntVal and at control bit 2 on the very next clock. The bench therefore compares both against an independent step model on every cycle of each run. A wrongly latched reload shadow or a missed one-pulse stop only becomes visible at the following update event, a few clocks later, as a wrap at the wrong value or a count that keeps moving. Direction gating errors in the compare path stay hidden until a status read, so each run ends with the sticky flags compared to the model's accumulated matches. A bad divider phase is caught by counting strobes across a window of eight clocks for each division code.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ALIGN_EDGE  = 2'd0,
    ALIGN_CDOWN = 2'd1,
    ALIGN_CUP   = 2'd2,
    ALIGN_CBOTH = 2'd3
  } align_e;

  // strobes and mode from control to datapath
  typedef struct packed {
    logic   run;
    align_e mode;
    logic   down;
    logic   dirClr;
  } dpCmd_t;

  localparam int CB_RUN     = 0;
  localparam int CB_ONESHOT = 1;
  localparam int CB_DIR     = 2;
  localparam int CB_MODE    = 3;
  localparam int CB_PRE     = 5;
  localparam int CB_DIV     = 8;
  localparam int SB_UPD     = 0;
  localparam int SB_CMP     = 1;

  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_RELOAD = 2'd1;
  localparam logic [1:0] A_CMP    = 2'd2;
  localparam logic [1:0] A_STAT   = 2'd3;
endpackage

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [CNT_W-1:0] arrActive,
  input  logic [CNT_W-1:0] arrReload,
  input  logic [CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0] cnt,
  output logic             updEv,
  output logic             hitEv,
  output logic             dirHw
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             dirQ;
  logic             atTop, atBot, bnd, nxtDir, goDown, dirOk;
  logic [CNT_W-1:0] nxtCnt;

  assign atTop = (cnt >= arrActive);
  assign atBot = (cnt == '0);

  always_comb begin
    bnd    = 1'b0;
    nxtCnt = cnt;
    nxtDir = dirQ;
    if (cmd.mode == ALIGN_EDGE) begin
      if (!cmd.down) begin
        bnd    = atTop;
        nxtCnt = atTop ? '0 : cnt + ONE;
      end else begin
        bnd    = atBot;
        nxtCnt = atBot ? arrReload : cnt - ONE;
      end
    end else if (!dirQ) begin
      bnd    = atTop;
      nxtCnt = atTop ? (atBot ? '0 : cnt - ONE) : cnt + ONE;
      nxtDir = atTop;
    end else begin
      bnd    = atBot;
      nxtCnt = atBot ? ((arrReload == '0) ? '0 : ONE) : cnt - ONE;
      nxtDir = !atBot;
    end
  end

  assign goDown = (cmd.mode == ALIGN_EDGE) ? cmd.down : dirQ;

  always_comb begin
    unique case (cmd.mode)
      ALIGN_CDOWN: dirOk = goDown;
      ALIGN_CUP:   dirOk = !goDown;
      default:     dirOk = 1'b1;
    endcase
  end

  assign updEv = cmd.run && bnd;
  assign hitEv = cmd.run && (cnt == cmpVal) && dirOk;
  assign dirHw = dirQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      dirQ <= 1'b0;
    end else begin
      if (cmd.run) cnt <= nxtCnt;
      if (cmd.dirClr) dirQ <= 1'b0;
      else if (cmd.run && cmd.mode != ALIGN_EDGE) dirQ <= nxtDir;
    end
  end

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.run |=> $stable(cnt));

  p_edge_up_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.run && cmd.mode == ALIGN_EDGE && !cmd.down && cnt < arrActive)
      |=> cnt == $past(cnt) + ONE);

  p_center_turn_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.run && cmd.mode != ALIGN_EDGE && updEv && !dirQ && !cmd.dirClr) |=> dirQ);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 16,
  parameter int MAX_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              updEv,
  input  logic              hitEv,
  input  logic              dirHw,
  output dpCmd_t            cmd,
  output logic [CNT_W-1:0]  arrActive,
  output logic [CNT_W-1:0]  arrShadow,
  output logic [CNT_W-1:0]  cmpVal,
  output logic              updFlag,
  output logic              cmpFlag,
  output logic              sampleStb
);
  localparam int DIV_W = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

  logic             runQ, oneShotQ, downQ, preQ;
  align_e           modeQ, newMode, modeNext;
  logic [1:0]       divQ;
  logic [DIV_W-1:0] divCnt, divLast;
  logic             wrCtrl, wrArr, wrCmp, wrStat;
  logic [DATA_W-1:0] ctrlWord, statWord;

  assign wrCtrl = regWr && regAddr == A_CTRL;
  assign wrArr  = regWr && regAddr == A_RELOAD;
  assign wrCmp  = regWr && regAddr == A_CMP;
  assign wrStat = regWr && regAddr == A_STAT;

  // edge-to-center switch refused while running
  assign newMode  = align_e'(regWrData[CB_MODE +: 2]);
  assign modeNext = (runQ && modeQ == ALIGN_EDGE && newMode != ALIGN_EDGE) ? modeQ : newMode;

  assign cmd.run    = runQ;
  assign cmd.mode   = modeQ;
  assign cmd.down   = downQ;
  assign cmd.dirClr = wrCtrl && (modeNext != modeQ);

  always_comb begin
    unique case (divQ)
      2'b01:   divLast = DIV_W'(1);
      2'b10:   divLast = DIV_W'(MAX_DIV - 1);
      default: divLast = '0;
    endcase
  end
  assign sampleStb = (divCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ      <= 1'b0;
      oneShotQ  <= 1'b0;
      downQ     <= 1'b0;
      modeQ     <= ALIGN_EDGE;
      preQ      <= 1'b0;
      divQ      <= 2'b00;
      arrShadow <= '0;
      arrActive <= '0;
      cmpVal    <= '0;
      updFlag   <= 1'b0;
      cmpFlag   <= 1'b0;
      divCnt    <= '0;
    end else begin
      if (wrCtrl) begin
        runQ     <= regWrData[CB_RUN];
        oneShotQ <= regWrData[CB_ONESHOT];
        if (modeQ == ALIGN_EDGE) downQ <= regWrData[CB_DIR];
        modeQ    <= modeNext;
        preQ     <= regWrData[CB_PRE];
        divQ     <= regWrData[CB_DIV +: 2];
      end else if (updEv && oneShotQ) begin
        runQ <= 1'b0;
      end
      if (wrArr) arrShadow <= regWrData[CNT_W-1:0];
      if (wrArr && !preQ) arrActive <= regWrData[CNT_W-1:0];
      else if (updEv) arrActive <= arrShadow;
      if (wrCmp) cmpVal <= regWrData[CNT_W-1:0];
      if (updEv) updFlag <= 1'b1;
      else if (wrStat && !regWrData[SB_UPD]) updFlag <= 1'b0;
      if (hitEv) cmpFlag <= 1'b1;
      else if (wrStat && !regWrData[SB_CMP]) cmpFlag <= 1'b0;
      divCnt <= (divCnt >= divLast) ? '0 : divCnt + 1'b1;
    end
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[CB_RUN]       = runQ;
    ctrlWord[CB_ONESHOT]   = oneShotQ;
    ctrlWord[CB_DIR]       = (modeQ == ALIGN_EDGE) ? downQ : dirHw;
    ctrlWord[CB_MODE +: 2] = modeQ;
    ctrlWord[CB_PRE]       = preQ;
    ctrlWord[CB_DIV +: 2]  = divQ;
    statWord = '0;
    statWord[SB_UPD] = updFlag;
    statWord[SB_CMP] = cmpFlag;
    unique case (regAddr)
      A_CTRL:   regRdData = ctrlWord;
      A_RELOAD: regRdData = DATA_W'(arrShadow);
      A_CMP:    regRdData = DATA_W'(cmpVal);
      default:  regRdData = statWord;
    endcase
  end

  p_onepulse_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (updEv && oneShotQ && !wrCtrl) |=> !runQ);

  p_mode_lock_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && runQ && modeQ == ALIGN_EDGE) |=> modeQ == ALIGN_EDGE);

  p_preload_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (preQ && !updEv) |=> $stable(arrActive));

  p_cmp_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmpFlag && !wrStat) |=> cmpFlag);

  p_stb_half_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && divQ == 2'b01 && !wrCtrl) |=> !sampleStb);
endmodule

// File: rtl/updown_timer.sv
module updown_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 16,
  parameter int MAX_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [CNT_W-1:0]  cntVal,
  output logic              updPulse,
  output logic              cmpFlag,
  output logic              sampleStb
);
  dpCmd_t           cmd;
  logic [CNT_W-1:0] arrActive, arrShadow, cmpVal;
  logic             updEv, hitEv, dirHw, updFlag;

  tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .MAX_DIV(MAX_DIV)) u_regs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regWrData(regWrData),
    .regRdData(regRdData), .updEv(updEv), .hitEv(hitEv), .dirHw(dirHw), .cmd(cmd),
    .arrActive(arrActive), .arrShadow(arrShadow), .cmpVal(cmpVal),
    .updFlag(updFlag), .cmpFlag(cmpFlag), .sampleStb(sampleStb)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rstN(rstN), .cmd(cmd), .arrActive(arrActive), .arrReload(arrShadow),
    .cmpVal(cmpVal), .cnt(cntVal), .updEv(updEv), .hitEv(hitEv), .dirHw(dirHw)
  );

  assign updPulse = updEv;

  p_flag_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    updEv |=> updFlag);
endmodule

// File: tb/updown_timer_tb.sv
module updown_timer_tb;
  import tmr_pkg::*;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic regWr = 1'b0;
  logic [15:0] regWrData = 16'd0;
  logic [15:0] regRdData;
  logic [W-1:0] cntVal;
  logic updPulse, cmpFlag, sampleStb;

  always #4 clk = ~clk;

  updown_timer u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regWrData(regWrData),
    .regRdData(regRdData), .cntVal(cntVal), .updPulse(updPulse), .cmpFlag(cmpFlag),
    .sampleStb(sampleStb)
  );

  typedef struct packed {
    logic [W-1:0] cnt;
    logic         upd;
    logic         dir;
  } item_t;

  item_t expQ[$];
  string curTag = "R2";
  int nChecks = 0, nFail = 0;
  bit done = 0;

  int refCnt = 0, arrA = 0, arrS = 0, cmpR = 0;
  int refMode = 0;
  bit refDir = 0, refDown = 0, refPre = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // control write mirrored into the reference state
  task automatic wrCtrl(input logic [15:0] d);
    int nm;
    nm = int'(d[4:3]);
    if (refMode == 0) refDown = d[2];
    if (nm != refMode) begin refDir = 0; refMode = nm; end
    refPre = d[5];
    wr(A_CTRL, d);
  endtask

  task automatic wrArr(input int v);
    wr(A_RELOAD, 16'(v));
    arrS = v;
    if (!refPre) arrA = v;
  endtask

  task automatic wrCmp(input int v);
    wr(A_CMP, 16'(v));
    cmpR = v;
  endtask

  task automatic clrStat();
    wr(A_STAT, 16'h0000);
  endtask

  // scoreboard monitor
  initial begin : mon
    item_t e;
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        chk(curTag, 32'(cntVal), 32'(e.cnt));
        chk(curTag, 32'(updPulse), 32'(e.upd));
        chk(curTag, 32'(regRdData[CB_DIR]), 32'(e.dir));
      end
    end
  end

  // driver: start a run, push the expected per-cycle items, stop, check flags
  task automatic runSeq(input int mode, input bit down, input int n,
                        input string tag, input string flagTag);
    int v, nx;
    bit d, nd, b, gd, ok, hit, upd;
    logic [15:0] word, st;
    item_t it;
    word = 16'h0001 | (16'(down) << CB_DIR) | (16'(mode) << CB_MODE) | (16'(refPre) << CB_PRE);
    curTag = tag;
    wrCtrl(word);
    v = refCnt; d = refDir; hit = 0; upd = 0;
    for (int k = 0; k <= n; k++) begin
      if (refMode == 0) begin
        gd = refDown; nd = d;
        if (!refDown) begin b = (v >= arrA); nx = b ? 0 : v + 1; end
        else begin b = (v == 0); nx = b ? arrS : v - 1; end
      end else if (!d) begin
        gd = 0; b = (v >= arrA); nx = b ? ((v == 0) ? 0 : v - 1) : v + 1; nd = b;
      end else begin
        gd = 1; b = (v == 0); nx = b ? ((arrS == 0) ? 0 : 1) : v - 1; nd = !b;
      end
      if (k > 0) begin
        it.cnt = W'(v); it.upd = b; it.dir = (refMode == 0) ? refDown : d;
        expQ.push_back(it);
      end
      ok = (refMode == 0) || (refMode == 3) || (refMode == 1 && gd) || (refMode == 2 && !gd);
      if (v == cmpR && ok) hit = 1;
      if (b) begin upd = 1; arrA = arrS; end
      v = nx; d = nd;
    end
    while (expQ.size() != 0) begin @(posedge clk); #3; end
    wrCtrl(word & ~16'h0001);
    refCnt = v; refDir = d;
    chk(tag, 32'(cntVal), 32'(v));
    rd(A_STAT, st);
    chk(tag, 32'(st[SB_UPD]), 32'(upd));
    chk(flagTag, 32'(st[SB_CMP]), 32'(hit));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] r;
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state and reserved bits
    rd(A_CTRL, r);   chk("R1", 32'(r), 32'h0);
    rd(A_RELOAD, r); chk("R1", 32'(r), 32'h0);
    rd(A_STAT, r);   chk("R1", 32'(r), 32'h0);
    chk("R1", 32'(cntVal), 32'h0);
    chk("R1", 32'(cmpFlag), 32'h0);
    wrCtrl(16'hFCC0);
    rd(A_CTRL, r);   chk("R1", 32'(r), 32'h0);

    // R2 edge-aligned up and down
    wrArr(3); wrCmp(2);
    runSeq(0, 0, 9, "R2", "R4"); clrStat();
    runSeq(0, 1, 9, "R2", "R4"); clrStat();

    // R3 / R4 center-aligned with direction gating
    wrCmp(3);
    runSeq(1, 0, 12, "R3", "R4"); clrStat();
    runSeq(2, 0, 12, "R3", "R4"); clrStat();
    wrCmp(0);
    runSeq(2, 0, 12, "R3", "R4"); clrStat();
    runSeq(3, 0, 12, "R3", "R4"); clrStat();

    // R5 direction read-only in center mode
    wr(A_CTRL, (16'd3 << CB_MODE) | (16'(!refDir) << CB_DIR));
    rd(A_CTRL, r); chk("R5", 32'(r[CB_DIR]), 32'(refDir));

    // R6 mode lock while running in edge mode
    wrCtrl(16'h0000);
    wrCtrl(16'h0001);
    wr(A_CTRL, 16'h0001 | (16'd3 << CB_MODE));
    rd(A_CTRL, r);
    chk("R6", 32'(r[4:3]), 32'h0);
    chk("R6", 32'(r[CB_RUN]), 32'h1);
    wrCtrl(16'h0000);
    refCnt = int'(cntVal);
    clrStat();

    // R7 buffered then immediate reload
    wrCtrl(16'h0001 << CB_PRE);
    wrArr(6);
    rd(A_RELOAD, r); chk("R7", 32'(r), 32'd6);
    runSeq(0, 0, 10, "R7", "R4"); clrStat();
    wrCtrl(16'h0000);
    wrArr(2);
    runSeq(0, 1, 8, "R7", "R4"); clrStat();

    // R8 one-pulse
    wrCtrl(16'h0003);
    repeat (10) @(negedge clk);
    rd(A_CTRL, r); chk("R8", 32'(r[CB_RUN]), 32'h0);
    chk("R8", 32'(cntVal), 32'h0);
    rd(A_STAT, r); chk("R8", 32'(r[SB_UPD]), 32'h1);
    repeat (5) @(negedge clk);
    chk("R8", 32'(cntVal), 32'h0);
    wrCtrl(16'h0000);
    refCnt = 0;
    clrStat();

    // R9 per-bit write-zero clearing
    wrCmp(1);
    runSeq(0, 0, 6, "R2", "R4");
    rd(A_STAT, r); chk("R9", 32'(r), 32'h3);
    wr(A_STAT, 16'h0002);
    rd(A_STAT, r); chk("R9", 32'(r), 32'h2);
    chk("R9", 32'(cmpFlag), 32'h1);
    wr(A_STAT, 16'h0001);
    rd(A_STAT, r); chk("R9", 32'(r), 32'h0);
    chk("R9", 32'(cmpFlag), 32'h0);

    // R10 sampling strobe with counter disabled
    for (int dv = 0; dv < 4; dv++) begin
      wrCtrl(16'(dv) << CB_DIV);
      repeat (4) @(negedge clk);
      cnt = 0;
      repeat (8) begin
        @(posedge clk);
        #2;
        if (sampleStb) cnt++;
      end
      chk("R10", 32'(cnt), (dv == 1) ? 32'd4 : (dv == 2) ? 32'd2 : 32'd8);
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule